// File: doc/BRIEF.md
# Byte and halfword rearrange unit

This combinational unit serves one group of register-to-register instructions that only move or replicate bits of a single source operand. It looks at the instruction word and the already-read source value, and it delivers the value to be written back, a write strobe, the destination register index and a flag for an encoding it must refuse. Five operations are supported. One swaps the two bytes inside every halfword of the low 32-bit word and widens that word with its sign. A second swaps the bytes inside all four halfwords of the 64-bit value. A third reverses the order of the four halfwords. The last two widen the low byte or the low halfword with its sign.

The group is recognised from the major opcode together with two function codes. The shift-amount field then selects the operation. A separate enable input says whether 64-bit operations are allowed, and the two doubleword forms are refused when it is low. Register files, forwarding and pipeline staging belong to the surrounding core.

Top module: `rearr_unit`

## Requirements
- R1: An instruction belongs to the group only when insn[31:26] = 011111 and insn[5:0] is 100000 or 100100. For any other word, wr_en = 0, illegal = 0 and result = 0.
- R2: A group word whose insn[25:21] is not zero, or whose shift-amount field insn[10:6] is not listed for its function code, gives illegal = 1, wr_en = 0 and result = 0.
- R3: With insn[10:6] = 00010 and function 100000, result[31:0] = {op[23:16], op[31:24], op[7:0], op[15:8]}, and every bit of result[63:32] equals result[31].
- R4: With insn[10:6] = 00010 and function 100100, each 16-bit halfword k of result (bits 16k+15:16k) holds the same halfword of op with its two bytes exchanged.
- R5: With insn[10:6] = 00101 and function 100100, halfword k of result equals halfword 3-k of op, for k = 0..3.
- R6: With insn[10:6] = 10000 and function 100000, result[7:0] = op[7:0], and every higher bit equals op[7].
- R7: With insn[10:6] = 11000 and function 100000, result[15:0] = op[15:0], and every higher bit equals op[15].
- R8: When dw_en = 0, the two operations with function 100100 give illegal = 1, wr_en = 0 and result = 0. The three operations with function 100000 do not depend on dw_en.
- R9: dst_idx always equals insn[15:11].
- R10: Each supported operation with its conditions met gives wr_en = 1 and illegal = 0. wr_en and illegal are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word under decode |
| op | input | 64 | Source operand value read from the register named by insn[20:16] |
| dw_en | input | 1 | High when 64-bit operations are permitted |
| result | output | 64 | Value to write back; zero when nothing is written |
| wr_en | output | 1 | Write strobe for the destination register |
| illegal | output | 1 | Group encoding that is refused |
| dst_idx | output | 5 | Destination register index |

## Verification
The assertions are evaluated whenever an input changes. They check that the write strobe and the refusal flag never rise together, that a refused or foreign word yields a zero result, and that a doubleword form with 64-bit operations disabled never writes. They also check the byte-level placement for each operation: the sign fill of the widened word, byte and halfword, the exchanged bytes, and the first reversed halfword. Only the bench scenarios show the full value for every halfword lane. The same holds for the exact decode boundary: nonzero source-field bits, neighbouring shift-amount codes and other function codes. The independence of the word forms from the 64-bit enable is likewise left to the bench.

// File: rtl/rearr_pkg.sv
package rearr_pkg;

   localparam int INSN_W = 32;
   localparam int REG_IDX_W = 5;

   localparam logic [5:0] OPC_GROUP  = 6'b011111;
   localparam logic [5:0] FN_NARROW  = 6'b100000;
   localparam logic [5:0] FN_WIDE    = 6'b100100;

   localparam logic [4:0] SA_SWAPB   = 5'b00010;
   localparam logic [4:0] SA_REVH    = 5'b00101;
   localparam logic [4:0] SA_SEXTB   = 5'b10000;
   localparam logic [4:0] SA_SEXTH   = 5'b11000;

   typedef enum logic [2:0] {
      RR_NONE    = 3'd0,
      RR_SWAPB_W = 3'd1,
      RR_SWAPB_D = 3'd2,
      RR_REVH_D  = 3'd3,
      RR_SEXT_B  = 3'd4,
      RR_SEXT_H  = 3'd5
   } rr_op_e;

   typedef struct packed {
      rr_op_e                 op;
      logic                   wr;
      logic                   bad;
      logic [REG_IDX_W-1:0]   dst;
   } rr_dec_t;

endpackage

// File: rtl/rearr_decode.sv
module rearr_decode
   import rearr_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   input  logic              dw_en,
   output rr_dec_t           dec
);

   logic [5:0] opc_f;
   logic [4:0] rs_f;
   logic [4:0] sa_f;
   logic [5:0] fn_f;
   logic       in_grp;
   rr_op_e     op_sel;
   logic       unused_rt;

   assign opc_f     = insn[31:26];
   assign rs_f      = insn[25:21];
   assign sa_f      = insn[10:6];
   assign fn_f      = insn[5:0];
   assign unused_rt = ^insn[20:16];

   assign in_grp = (opc_f == OPC_GROUP) && ((fn_f == FN_NARROW) || (fn_f == FN_WIDE));

   always_comb begin
      op_sel = RR_NONE;
      if (in_grp && (rs_f == 5'd0)) begin
         if (fn_f == FN_NARROW) begin
            if (sa_f == SA_SWAPB)      op_sel = RR_SWAPB_W;
            else if (sa_f == SA_SEXTB) op_sel = RR_SEXT_B;
            else if (sa_f == SA_SEXTH) op_sel = RR_SEXT_H;
         end else if (dw_en) begin
            if (sa_f == SA_SWAPB)      op_sel = RR_SWAPB_D;
            else if (sa_f == SA_REVH)  op_sel = RR_REVH_D;
         end
      end
   end

   assign dec.op  = op_sel;
   assign dec.wr  = (op_sel != RR_NONE);
   assign dec.bad = in_grp && (op_sel == RR_NONE);
   assign dec.dst = insn[15:11];

endmodule

// File: rtl/rearr_lanes.sv
module rearr_lanes #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] byte_swapped,
   output logic [DATA_W-1:0] lane_reversed
);

   localparam int N_LANES = DATA_W / LANE_W;
   localparam int N_BYTES = LANE_W / BYTE_W;

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
         assign byte_swapped[l*LANE_W + b*BYTE_W +: BYTE_W] =
            din[l*LANE_W + (N_BYTES-1-b)*BYTE_W +: BYTE_W];
      end
      assign lane_reversed[l*LANE_W +: LANE_W] = din[(N_LANES-1-l)*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/rearr_sext.sv
module rearr_sext #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 64
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   if (OUT_W <= IN_W) begin : g_bad_w
      $error("rearr_sext: OUT_W must exceed IN_W");
   end

   assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};

endmodule

// File: rtl/rearr_unit.sv
module rearr_unit
   import rearr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [INSN_W-1:0]    insn,
   input  logic [DATA_W-1:0]    op,
   input  logic                 dw_en,
   output logic [DATA_W-1:0]    result,
   output logic                 wr_en,
   output logic                 illegal,
   output logic [REG_IDX_W-1:0] dst_idx
);

   localparam int WORD_W = DATA_W / 2;

   if ((DATA_W % (2*LANE_W)) != 0) begin : g_chk_data
      $error("rearr_unit: DATA_W must be a multiple of two lanes");
   end
   if ((LANE_W % BYTE_W) != 0 || LANE_W <= BYTE_W) begin : g_chk_lane
      $error("rearr_unit: LANE_W must hold at least two whole bytes");
   end

   rr_dec_t           dec;
   logic [DATA_W-1:0] swp;
   logic [DATA_W-1:0] rev;
   logic [DATA_W-1:0] sx_word;
   logic [DATA_W-1:0] sx_byte;
   logic [DATA_W-1:0] sx_half;

   rearr_decode u_dec (
      .insn  (insn),
      .dw_en (dw_en),
      .dec   (dec)
   );

   rearr_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_lanes (
      .din           (op),
      .byte_swapped  (swp),
      .lane_reversed (rev)
   );

   rearr_sext #(.IN_W(WORD_W), .OUT_W(DATA_W)) u_sx_word (
      .din  (swp[WORD_W-1:0]),
      .dout (sx_word)
   );

   rearr_sext #(.IN_W(BYTE_W), .OUT_W(DATA_W)) u_sx_byte (
      .din  (op[BYTE_W-1:0]),
      .dout (sx_byte)
   );

   rearr_sext #(.IN_W(LANE_W), .OUT_W(DATA_W)) u_sx_half (
      .din  (op[LANE_W-1:0]),
      .dout (sx_half)
   );

   always_comb begin
      unique case (dec.op)
         RR_SWAPB_W: result = sx_word;
         RR_SWAPB_D: result = swp;
         RR_REVH_D:  result = rev;
         RR_SEXT_B:  result = sx_byte;
         RR_SEXT_H:  result = sx_half;
         default:    result = '0;
      endcase
   end

   assign wr_en   = dec.wr;
   assign illegal = dec.bad;
   assign dst_idx = dec.dst;

endmodule

// File: rtl/rearr_unit_chk.sv
module rearr_unit_chk
   import rearr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int BYTE_W = 8
) (
   input logic [INSN_W-1:0]    insn,
   input logic [DATA_W-1:0]    op,
   input logic                 dw_en,
   input logic [DATA_W-1:0]    result,
   input logic                 wr_en,
   input logic                 illegal,
   input logic [REG_IDX_W-1:0] dst_idx
);

   localparam int WORD_W = DATA_W / 2;

   logic known;
   logic in_opc;
   logic is_nar;
   logic is_wide;

   assign known   = !$isunknown({insn, op, dw_en});
   assign in_opc  = (insn[31:26] == OPC_GROUP);
   assign is_nar  = in_opc && (insn[5:0] == FN_NARROW);
   assign is_wide = in_opc && (insn[5:0] == FN_WIDE);

   always_comb begin
      if (known) begin
         // R10
         a_r10_flags_exclusive: assert (!(wr_en && illegal));
         // R2
         a_r2_refused_zero: assert (!illegal || (result == '0));
         // R1
         a_r1_foreign_quiet: assert ((is_nar || is_wide) || (!wr_en && !illegal && result == '0));
         // R8
         a_r8_wide_gated: assert (!(is_wide && !dw_en) || (!wr_en && illegal));
         // R9
         a_r9_dst_field: assert (dst_idx == insn[15:11]);
         // R6
         a_r6_byte_fill: assert (!(wr_en && is_nar && insn[10:6] == SA_SEXTB) ||
            ((result[BYTE_W-1:0] == op[BYTE_W-1:0]) &&
             (result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){op[BYTE_W-1]}})));
         // R7
         a_r7_half_fill: assert (!(wr_en && is_nar && insn[10:6] == SA_SEXTH) ||
            ((result[LANE_W-1:0] == op[LANE_W-1:0]) &&
             (result[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){op[LANE_W-1]}})));
         // R3
         a_r3_word_fill: assert (!(wr_en && is_nar && insn[10:6] == SA_SWAPB) ||
            ((result[DATA_W-1:WORD_W] == {WORD_W{result[WORD_W-1]}}) &&
             (result[BYTE_W-1:0] == op[2*BYTE_W-1:BYTE_W])));
         // R4
         a_r4_low_swap: assert (!(wr_en && is_wide && insn[10:6] == SA_SWAPB) ||
            ((result[BYTE_W-1:0] == op[2*BYTE_W-1:BYTE_W]) &&
             (result[DATA_W-1 -: BYTE_W] == op[DATA_W-BYTE_W-1 -: BYTE_W])));
         // R5
         a_r5_first_lane: assert (!(wr_en && is_wide && insn[10:6] == SA_REVH) ||
            (result[LANE_W-1:0] == op[DATA_W-1 -: LANE_W]));
      end
   end

endmodule

bind rearr_unit rearr_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/rearr_unit_test.sv
module rearr_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] insn = 32'd0;
   logic [63:0] op = 64'd0;
   logic        dw_en = 1'b0;
   logic [63:0] result;
   logic        wr_en;
   logic        illegal;
   logic [4:0]  dst_idx;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rearr_unit uut (
      .insn    (insn),
      .op      (op),
      .dw_en   (dw_en),
      .result  (result),
      .wr_en   (wr_en),
      .illegal (illegal),
      .dst_idx (dst_idx)
   );

   // behavioural expectation
   task automatic model(input logic [31:0] i, input logic [63:0] v, input logic de,
                        output logic [63:0] e_res, output logic e_wr, output logic e_ill,
                        output string tag);
      byte unsigned bt[8];
      logic [15:0]  hw[4];
      logic [31:0]  w;
      for (int k = 0; k < 8; k++) bt[k] = v[8*k +: 8];
      for (int k = 0; k < 4; k++) hw[k] = v[16*k +: 16];
      e_res = 64'd0; e_wr = 1'b0; e_ill = 1'b0; tag = "R1";
      if (i[31:26] == 6'h1f && (i[5:0] == 6'h20 || i[5:0] == 6'h24)) begin
         e_ill = 1'b1; tag = "R2";
         if (i[25:21] == 5'd0) begin
            if (i[5:0] == 6'h20 && i[10:6] == 5'd2) begin
               w = {bt[2], bt[3], bt[0], bt[1]};
               e_res = {{32{w[31]}}, w}; e_ill = 1'b0; e_wr = 1'b1; tag = "R3";
            end else if (i[5:0] == 6'h20 && i[10:6] == 5'd16) begin
               e_res = {{56{v[7]}}, v[7:0]}; e_ill = 1'b0; e_wr = 1'b1; tag = "R6";
            end else if (i[5:0] == 6'h20 && i[10:6] == 5'd24) begin
               e_res = {{48{v[15]}}, v[15:0]}; e_ill = 1'b0; e_wr = 1'b1; tag = "R7";
            end else if (i[5:0] == 6'h24 && (i[10:6] == 5'd2 || i[10:6] == 5'd5)) begin
               if (!de) tag = "R8";
               else begin
                  e_ill = 1'b0; e_wr = 1'b1;
                  if (i[10:6] == 5'd2) begin
                     tag = "R4";
                     for (int k = 0; k < 4; k++) e_res[16*k +: 16] = {bt[2*k], bt[2*k+1]};
                  end else begin
                     tag = "R5";
                     for (int k = 0; k < 4; k++) e_res[16*k +: 16] = hw[3-k];
                  end
               end
            end
         end
      end
   endtask

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] i, input logic [63:0] v, input logic de);
      logic [63:0] e_res;
      logic        e_wr;
      logic        e_ill;
      string       tag;
      @(posedge clk);
      #1;
      insn = i; op = v; dw_en = de;
      model(i, v, de, e_res, e_wr, e_ill, tag);
      @(negedge clk);
      check(tag, "result", result, e_res);
      check((e_wr || e_ill) ? "R10" : "R1", "wr_en", {63'd0, wr_en}, {63'd0, e_wr});
      check((e_ill) ? tag : "R10", "illegal", {63'd0, illegal}, {63'd0, e_ill});
      check("R9", "dst_idx", {59'd0, dst_idx}, {59'd0, i[15:11]});
   endtask

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [4:0] rd,
                                      input logic [4:0] sa, input logic [5:0] fn);
      return {opc, rs, rt, rd, sa, fn};
   endfunction

   initial begin
      #200000;
      if (!done) begin
         bad++; total++;
         $display("FAIL R1 watchdog expired: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] pat[4];
      pat[0] = 64'h0123_4567_89ab_cdef;
      pat[1] = 64'hfedc_ba98_7654_3210;
      pat[2] = 64'h8000_0000_7fff_ff80;
      pat[3] = 64'h0000_0000_0000_007f;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle word after reset: R1
      apply(32'd0, 64'd0, 1'b0);
      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d < 2; d++) begin
            apply(mk(6'h1f, 5'd0, 5'd3, 5'd7,  5'd2,  6'h20), pat[p], d[0]); // R3
            apply(mk(6'h1f, 5'd0, 5'd3, 5'd8,  5'd2,  6'h24), pat[p], d[0]); // R4 / R8
            apply(mk(6'h1f, 5'd0, 5'd3, 5'd9,  5'd5,  6'h24), pat[p], d[0]); // R5 / R8
            apply(mk(6'h1f, 5'd0, 5'd3, 5'd10, 5'd16, 6'h20), pat[p], d[0]); // R6
            apply(mk(6'h1f, 5'd0, 5'd3, 5'd31, 5'd24, 6'h20), pat[p], d[0]); // R7
         end
         // R2 boundaries: neighbouring codes and nonzero rs
         apply(mk(6'h1f, 5'd1,  5'd3, 5'd4, 5'd2,  6'h20), pat[p], 1'b1);
         apply(mk(6'h1f, 5'd16, 5'd3, 5'd4, 5'd5,  6'h24), pat[p], 1'b1);
         apply(mk(6'h1f, 5'd0,  5'd3, 5'd4, 5'd3,  6'h20), pat[p], 1'b1);
         apply(mk(6'h1f, 5'd0,  5'd3, 5'd4, 5'd5,  6'h20), pat[p], 1'b1);
         apply(mk(6'h1f, 5'd0,  5'd3, 5'd4, 5'd16, 6'h24), pat[p], 1'b1);
         apply(mk(6'h1f, 5'd0,  5'd3, 5'd4, 5'd0,  6'h24), pat[p], 1'b1);
         // R1: other function or opcode
         apply(mk(6'h1f, 5'd0,  5'd3, 5'd4, 5'd2,  6'h21), pat[p], 1'b1);
         apply(mk(6'h1e, 5'd0,  5'd3, 5'd4, 5'd2,  6'h20), pat[p], 1'b1);
         apply(mk(6'h3f, 5'd0,  5'd3, 5'd4, 5'd5,  6'h24), pat[p], 1'b1);
      end
      // mixed sweep
      for (int n = 0; n < 400; n++) begin
         logic [5:0] opc;
         logic [5:0] fn;
         logic [4:0] sa;
         logic [4:0] rs;
         logic [4:0] sel;
         sel = 5'($urandom_range(0, 7));
         case (sel)
            5'd0: sa = 5'd2;  5'd1: sa = 5'd5;  5'd2: sa = 5'd16; 5'd3: sa = 5'd24;
            default: sa = 5'($urandom);
         endcase
         opc = ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'h1f;
         fn  = ($urandom_range(0, 5) == 0) ? 6'($urandom) : (($urandom_range(0, 1) == 0) ? 6'h20 : 6'h24);
         rs  = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
         apply(mk(opc, rs, 5'($urandom), 5'($urandom), sa, fn),
               {32'($urandom), 32'($urandom)}, 1'($urandom));
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule